// File: doc/BRIEF.md
# Extended-Range Degamma Lookup Unit

This unit applies a programmable degamma curve to pixel channel values before the colour-space matrix of one display pipe. The curve is a 35-point table. Points 0 to 32 are evenly spaced over inputs 0.0 to 1.0. Point 33 sits at input 3.0 and point 34 at input 7.0. Each channel value is mapped through the table by piecewise-linear interpolation between the two points around it. Inputs above 7.0 clamp to the last point.

Software reaches the table through an index register and a data register. The index can advance by itself after each data access. A mode register holds the enable for the curve. While the curve is disabled, the unit passes each value through unchanged with the same one-cycle latency. All values use unsigned fixed point with 3 integer bits and 16 fractional bits, so 1.0 is 0x10000. Table entries are stored at full width, so the point at 1.0 may hold a value above 1.0.

Top module: `degamma_xr_unit`

## Requirements
- R1: After synchronous reset:
  - the index is 0, auto-increment is off and the curve is disabled;
  - entry i holds i*0x800 for i from 0 to 32, entry 33 holds 0x30000 and entry 34 holds 0x70000;
  - all channel outputs are 0.
- R2: `reg_sel` selects a register: 0 = index, 1 = data, 2 = mode, 3 = unused (reads 0). Mode bit 31 enables the curve and reads back at bit 31. All other mode bits, bit 30 included, are ignored and read as 0.
- R3: Index register layout: index in bits [5:0], auto-increment in bit 15.
  - A write with bit 15 clear turns auto-increment off and leaves the index unchanged.
  - A write with bit 15 set while auto-increment is off turns it on and loads the index. Values above 35 load as 35.
  - A write with bit 15 set while auto-increment is already on changes nothing.
- R4: A data write stores bits [18:0] into the entry at the current index. A data read returns that entry zero-extended on `reg_rdata` in the same cycle. With auto-increment on, each data access advances the index by one. With it off, the index stays where it is.
- R5: Index 35 is a past-the-end state. The index never goes beyond it. At 35, data writes change no entry and data reads return 0.
- R6: For an enabled input x below 0x10000: segment s = x[15:11], fraction f = x[10:0], output = e[s] + floor((e[s+1]-e[s])*f/2048).
- R7: For an enabled input x from 0x10000 up to but not including 0x30000: output = e32 + floor((e33-e32)*(x-0x10000)/0x20000).
- R8: For an enabled input x from 0x30000 up to but not including 0x70000: output = e33 + floor((e34-e33)*(x-0x30000)/0x40000).
- R9: For an enabled input x of 0x70000 or above, the output is e34.
- R10: With the curve disabled, each output equals the input presented one cycle earlier.
- R11: Outputs are registered. A channel value presented before a rising edge appears after that edge, in both modes. The table contents and enable used are the ones in effect before that edge.
- R12: The channels are processed independently and in parallel. Channel c occupies bits [19c+18:19c] of the pixel buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data register side effect) |
| reg_sel | input | 2 | Register select: 0 index, 1 data, 2 mode |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| pix_in | input | 57 | Input channel values, 19 bits each |
| pix_out | output | 57 | Output channel values, registered |

## Verification
The bench builds the unit with its default parameters: three channels, 16 fractional and 3 integer bits, and 5 segment bits. These defaults give 33 even points plus the two sparse ones and a 6-bit index. With them the bench can walk the index through all 35 entries into the past-the-end state and write a non-monotonic table with a point above 1.0. It then drives inputs into all four regions: even segments, the 1-3 span, the 3-7 span and the clamp. That covers negative interpolation slopes and the exact breakpoints 1.0, 3.0 and 7.0.

// File: rtl/dgx_pkg.sv
// Package: register select codes and bit positions for the degamma unit.
// Assumes a 2-bit register select and 32-bit register words.
package dgx_pkg;
    localparam logic [1:0] SEL_INDEX = 2'd0;
    localparam logic [1:0] SEL_DATA  = 2'd1;
    localparam logic [1:0] SEL_MODE  = 2'd2;
    localparam logic [1:0] SEL_SPARE = 2'd3;

    // Auto-increment control bit in the index register.
    localparam int AI_BIT = 15;
    // Curve enable bit in the mode register.
    localparam int EN_BIT = 31;
    localparam int REG_W  = 32;
endpackage

// File: rtl/dgx_regs.sv
// Module: register interface and table storage for the degamma unit.
// Holds the index, the auto-increment flag, the enable bit and the 35 entries.
// Assumes one access per cycle; reg_rdata is combinational from current state.
// Index value N_ENT is a past-the-end state where data accesses have no effect.
module dgx_regs #(
    parameter int PIX_W    = 19,
    parameter int FRAC_W   = 16,
    parameter int SEG_BITS = 5,
    parameter int N_ENT    = 35,
    parameter int IDX_W    = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_wr,
    input  logic                    acc_rd,
    input  logic [1:0]              acc_sel,
    input  logic [31:0]             acc_wdata,
    output logic [31:0]             acc_rdata,
    output logic                    mode_en,
    output logic [IDX_W-1:0]        cur_idx,
    output logic                    auto_inc,
    output logic [N_ENT*PIX_W-1:0]  tbl_flat
);
    import dgx_pkg::*;

    localparam int N_EVEN = N_ENT - 2;
    localparam int STEP_W = FRAC_W - SEG_BITS;
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(N_ENT);

    // Reset value of entry i: identity over the whole range.
    function automatic logic [PIX_W-1:0] ident(input int i);
        if (i < N_EVEN)
            return PIX_W'(i << STEP_W);
        else if (i == N_EVEN)
            return PIX_W'(3 << FRAC_W);
        else
            return PIX_W'(7 << FRAC_W);
    endfunction

    logic             sel_index, sel_data, sel_mode;
    logic             data_access, data_we, at_end;
    logic [IDX_W-1:0] load_idx;
    logic [PIX_W-1:0] rd_entry;
    logic             wdata_unused;

    assign sel_index    = (acc_sel == SEL_INDEX);
    assign sel_data     = (acc_sel == SEL_DATA);
    assign sel_mode     = (acc_sel == SEL_MODE);
    assign at_end       = (cur_idx == IDX_END);
    assign data_access  = (acc_wr || acc_rd) && sel_data;
    assign data_we      = acc_wr && sel_data && !at_end;
    assign wdata_unused = ^acc_wdata[EN_BIT-1:PIX_W];

    // Index field clamp: anything past the end loads as past-the-end.
    assign load_idx = (acc_wdata[IDX_W-1:0] > IDX_END) ? IDX_END : acc_wdata[IDX_W-1:0];

    // Index and auto-increment state with the clear-then-set load ordering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx  <= '0;
            auto_inc <= 1'b0;
        end else if (acc_wr && sel_index) begin
            if (!acc_wdata[AI_BIT]) begin
                auto_inc <= 1'b0;
            end else if (!auto_inc) begin
                auto_inc <= 1'b1;
                cur_idx  <= load_idx;
            end
        end else if (data_access && auto_inc && !at_end) begin
            cur_idx <= cur_idx + 1'b1;
        end
    end

    // Curve enable bit of the mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_en <= 1'b0;
        else if (acc_wr && sel_mode)
            mode_en <= acc_wdata[EN_BIT];
    end

    // Table storage: one register per entry, reset to the identity curve.
    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic [PIX_W-1:0] ent;

        // Entry g: loads on a data write addressed at it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent <= ident(g);
            else if (data_we && cur_idx == IDX_W'(g))
                ent <= acc_wdata[PIX_W-1:0];
        end

        assign tbl_flat[g*PIX_W +: PIX_W] = ent;
    end

    // Entry at the current index, zero once past the end.
    always_comb begin
        rd_entry = '0;
        if (!at_end)
            rd_entry = tbl_flat[cur_idx*PIX_W +: PIX_W];
    end

    // Register read mux.
    always_comb begin
        acc_rdata = '0;
        unique case (acc_sel)
            SEL_INDEX: begin
                acc_rdata[IDX_W-1:0] = cur_idx;
                acc_rdata[AI_BIT]    = auto_inc;
            end
            SEL_DATA:  acc_rdata[PIX_W-1:0] = rd_entry;
            SEL_MODE:  acc_rdata[EN_BIT]    = mode_en;
            default:   acc_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dgx_segsel.sv
// Module: segment selection for one channel.
// Maps an input value to the pair of table points around it.
// Also produces an interpolation fraction normalised to NORM_W bits.
// Assumes the two sparse points sit at 3.0 and 7.0, which requires at least 3 integer bits.
module dgx_segsel #(
    parameter int PIX_W    = 19,
    parameter int FRAC_W   = 16,
    parameter int SEG_BITS = 5,
    parameter int N_ENT    = 35,
    parameter int IDX_W    = 6,
    parameter int NORM_W   = 18
) (
    input  logic [PIX_W-1:0]  x,
    output logic [IDX_W-1:0]  idx_lo,
    output logic [IDX_W-1:0]  idx_hi,
    output logic [NORM_W-1:0] frac
);
    localparam int STEP_W = FRAC_W - SEG_BITS;
    localparam int N_EVEN = N_ENT - 2;
    localparam logic [PIX_W-1:0] ONE   = PIX_W'(1 << FRAC_W);
    localparam logic [PIX_W-1:0] THREE = PIX_W'(3 << FRAC_W);
    localparam logic [PIX_W-1:0] SEVEN = PIX_W'(7 << FRAC_W);
    localparam logic [IDX_W-1:0] P_ONE   = IDX_W'(N_EVEN - 1);
    localparam logic [IDX_W-1:0] P_THREE = IDX_W'(N_EVEN);
    localparam logic [IDX_W-1:0] P_SEVEN = IDX_W'(N_EVEN + 1);

    logic [PIX_W-1:0] off_one, off_three;

    assign off_one   = x - ONE;
    assign off_three = x - THREE;

    // Region decode: even segments, 1-3 span, 3-7 span, clamp.
    always_comb begin
        if (x < ONE) begin
            idx_lo = IDX_W'(x[FRAC_W-1:STEP_W]);
            idx_hi = IDX_W'(x[FRAC_W-1:STEP_W]) + 1'b1;
            frac   = {x[STEP_W-1:0], {(NORM_W-STEP_W){1'b0}}};
        end else if (x < THREE) begin
            idx_lo = P_ONE;
            idx_hi = P_THREE;
            frac   = NORM_W'(off_one << 1);
        end else if (x < SEVEN) begin
            idx_lo = P_THREE;
            idx_hi = P_SEVEN;
            frac   = NORM_W'(off_three);
        end else begin
            idx_lo = P_SEVEN;
            idx_hi = P_SEVEN;
            frac   = '0;
        end
    end
endmodule

// File: rtl/dgx_interp.sv
// Module: linear interpolation and output register for one channel.
// Computes e0 + floor((e1-e0)*frac / 2^NORM_W) and registers it,
// or registers the raw input when the curve is disabled.
// Assumes e0/e1 unsigned. The result is clamped to the output range as a guard.
module dgx_interp #(
    parameter int PIX_W  = 19,
    parameter int NORM_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PIX_W-1:0]  x,
    input  logic [PIX_W-1:0]  e0,
    input  logic [PIX_W-1:0]  e1,
    input  logic [NORM_W-1:0] frac,
    output logic [PIX_W-1:0]  y
);
    localparam int D_W = PIX_W + 1;
    localparam int P_W = D_W + NORM_W + 1;

    logic signed [D_W-1:0] diff;
    logic signed [P_W-1:0] prod;
    logic signed [D_W-1:0] step;
    logic signed [D_W:0]   sum;
    logic [PIX_W-1:0]      curve;

    assign diff = $signed({1'b0, e1}) - $signed({1'b0, e0});
    assign prod = diff * $signed({1'b0, frac});
    assign step = D_W'(prod >>> NORM_W);
    assign sum  = $signed({2'b00, e0}) + $signed({step[D_W-1], step});

    // Guard clamp on the interpolated sum.
    always_comb begin
        if (sum[D_W])
            curve = '0;
        else if (sum[D_W-1])
            curve = '1;
        else
            curve = sum[PIX_W-1:0];
    end

    // Output register: curve or bypass.
    always_ff @(posedge clk) begin
        if (!rst_n)
            y <= '0;
        else
            y <= en ? curve : x;
    end
endmodule

// File: rtl/degamma_xr_unit.sv
// Module: extended-range degamma unit, top level.
// Ties the register block to one segment selector and one interpolator per channel.
// Assumes the channels share the table and the enable bit.
module degamma_xr_unit #(
    parameter int NUM_CH   = 3,
    parameter int FRAC_W   = 16,
    parameter int INT_W    = 3,
    parameter int SEG_BITS = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [1:0]                reg_sel,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    input  logic [NUM_CH*(INT_W+FRAC_W)-1:0] pix_in,
    output logic [NUM_CH*(INT_W+FRAC_W)-1:0] pix_out
);
    localparam int PIX_W  = INT_W + FRAC_W;
    localparam int N_EVEN = (1 << SEG_BITS) + 1;
    localparam int N_ENT  = N_EVEN + 2;
    localparam int IDX_W  = $clog2(N_ENT + 1);
    localparam int NORM_W = FRAC_W + 2;

    logic                   mode_en;
    logic                   auto_inc;
    logic [IDX_W-1:0]       cur_idx;
    logic [N_ENT*PIX_W-1:0] tbl_flat;

    dgx_regs #(
        .PIX_W(PIX_W), .FRAC_W(FRAC_W), .SEG_BITS(SEG_BITS),
        .N_ENT(N_ENT), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .acc_wr(reg_wr), .acc_rd(reg_rd), .acc_sel(reg_sel),
        .acc_wdata(reg_wdata), .acc_rdata(reg_rdata),
        .mode_en(mode_en), .cur_idx(cur_idx), .auto_inc(auto_inc),
        .tbl_flat(tbl_flat)
    );

    // One datapath per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [PIX_W-1:0]  x;
        logic [IDX_W-1:0]  lo, hi;
        logic [NORM_W-1:0] frac;
        logic [PIX_W-1:0]  e0, e1;

        assign x  = pix_in[c*PIX_W +: PIX_W];
        assign e0 = tbl_flat[lo*PIX_W +: PIX_W];
        assign e1 = tbl_flat[hi*PIX_W +: PIX_W];

        dgx_segsel #(
            .PIX_W(PIX_W), .FRAC_W(FRAC_W), .SEG_BITS(SEG_BITS),
            .N_ENT(N_ENT), .IDX_W(IDX_W), .NORM_W(NORM_W)
        ) u_seg (
            .x(x), .idx_lo(lo), .idx_hi(hi), .frac(frac)
        );

        dgx_interp #(
            .PIX_W(PIX_W), .NORM_W(NORM_W)
        ) u_int (
            .clk(clk), .rst_n(rst_n), .en(mode_en), .x(x),
            .e0(e0), .e1(e1), .frac(frac),
            .y(pix_out[c*PIX_W +: PIX_W])
        );
    end
endmodule

// File: rtl/dgx_checker.sv
// Module: property checker for the degamma unit, bound to the top level.
// Observes the register strobes, the index state and the pixel buses.
module dgx_checker #(
    parameter int NUM_CH = 3,
    parameter int PIX_W  = 19,
    parameter int N_ENT  = 35,
    parameter int IDX_W  = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_wr,
    input logic                    acc_rd,
    input logic [1:0]              acc_sel,
    input logic                    wr_ai,
    input logic [IDX_W-1:0]        idx,
    input logic                    auto_inc,
    input logic                    enable,
    input logic [NUM_CH*PIX_W-1:0] pix_in,
    input logic [NUM_CH*PIX_W-1:0] pix_out
);
    import dgx_pkg::*;
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(N_ENT);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (idx == '0 && !auto_inc && !enable));

    assert_clear_keeps_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_sel == SEL_INDEX && !wr_ai) |=> (!auto_inc && idx == $past(idx)));

    assert_reload_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_sel == SEL_INDEX && wr_ai && auto_inc) |=> (auto_inc && $stable(idx)));

    assert_auto_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_wr || acc_rd) && acc_sel == SEL_DATA && auto_inc && idx < IDX_END)
        |=> (idx == IDX_W'($past(idx) + 1'b1)));

    assert_index_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_END);

    assert_end_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == IDX_END && auto_inc) |=> (idx == IDX_END));

    assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pix_out == $past(pix_in)));
endmodule

bind degamma_xr_unit dgx_checker #(
    .NUM_CH(NUM_CH), .PIX_W(PIX_W), .N_ENT(N_ENT), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_wr(reg_wr), .acc_rd(reg_rd),
    .acc_sel(reg_sel), .wr_ai(reg_wdata[dgx_pkg::AI_BIT]),
    .idx(cur_idx), .auto_inc(auto_inc), .enable(mode_en),
    .pix_in(pix_in), .pix_out(pix_out)
);

// File: tb/degamma_xr_unit_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus directed checks.
module degamma_xr_unit_tb;
    localparam int NUM_CH = 3;
    localparam int PIX_W  = 19;
    localparam int N_ENT  = 35;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic reg_rd = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NUM_CH*PIX_W-1:0] pix_in = '0;
    logic [NUM_CH*PIX_W-1:0] pix_out;

    always #2.5 clk = ~clk;

    degamma_xr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pix_in(pix_in), .pix_out(pix_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit model_live = 1'b0;

    longint m_tbl[N_ENT];
    int     m_idx;
    bit     m_ai, m_en;
    longint m_out[NUM_CH];
    string  m_tag[NUM_CH];

    task automatic chk(string tag, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic longint fdiv(longint a, longint b);
        if (a >= 0) return a / b;
        return -((-a + b - 1) / b);
    endfunction

    function automatic longint curve(longint x);
        longint s, f;
        if (x < 65536) begin
            s = x / 2048; f = x % 2048;
            return m_tbl[s] + fdiv((m_tbl[s+1] - m_tbl[s]) * f, 2048);
        end else if (x < 196608) begin
            return m_tbl[32] + fdiv((m_tbl[33] - m_tbl[32]) * (x - 65536), 131072);
        end else if (x < 458752) begin
            return m_tbl[33] + fdiv((m_tbl[34] - m_tbl[33]) * (x - 196608), 262144);
        end
        return m_tbl[34];
    endfunction

    function automatic string region(longint x);
        if (x < 65536) return "R6";
        if (x < 196608) return "R7";
        if (x < 458752) return "R8";
        return "R9";
    endfunction

    function automatic longint model_rdata(logic [1:0] s);
        case (s)
            2'd0: return (longint'(m_ai) << 15) | m_idx;
            2'd1: return (m_idx < N_ENT) ? m_tbl[m_idx] : 0;
            2'd2: return longint'(m_en) << 31;
            default: return 0;
        endcase
    endfunction

    function automatic longint ident(int i);
        if (i < 33) return i * 2048;
        if (i == 33) return 196608;
        return 458752;
    endfunction

    // Reference model: state after each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) m_tbl[i] = ident(i);
            m_idx = 0; m_ai = 0; m_en = 0;
            for (int c = 0; c < NUM_CH; c++) begin m_out[c] = 0; m_tag[c] = "R1"; end
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                longint x;
                x = pix_in[c*PIX_W +: PIX_W];
                m_out[c] = m_en ? curve(x) : x;
                m_tag[c] = m_en ? region(x) : "R10";
            end
            if (reg_wr) begin
                case (reg_sel)
                    2'd0: if (!reg_wdata[15]) m_ai = 0;
                          else if (!m_ai) begin
                              m_ai = 1;
                              m_idx = (reg_wdata[5:0] > 35) ? 35 : int'(reg_wdata[5:0]);
                          end
                    2'd1: if (m_idx < N_ENT) begin
                              m_tbl[m_idx] = reg_wdata[18:0];
                              if (m_ai) m_idx++;
                          end
                    2'd2: m_en = reg_wdata[31];
                    default: ;
                endcase
            end else if (reg_rd && reg_sel == 2'd1 && m_ai && m_idx < N_ENT) begin
                m_idx++;
            end
        end
    end

    // Every-clock comparison against the model (R11, R12 and per-region tags).
    always @(negedge clk) begin
        if (model_live) begin
            for (int c = 0; c < NUM_CH; c++)
                chk({m_tag[c], "/R11/R12"}, longint'(pix_out[c*PIX_W +: PIX_W]), m_out[c]);
            if (reg_rd)
                chk(reg_sel == 2'd1 ? "R4" : (reg_sel == 2'd0 ? "R3" : "R2"),
                    longint'(reg_rdata), model_rdata(reg_sel));
        end
    end

    task automatic wr_reg(logic [1:0] s, logic [31:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] s, output logic [31:0] v);
        reg_rd = 1'b1; reg_sel = s;
        @(negedge clk); v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic put_pix(longint a, longint b, longint c);
        pix_in = {PIX_W'(c), PIX_W'(b), PIX_W'(a)};
        @(posedge clk); #1;
    endtask

    function automatic longint ch(int c);
        return longint'(pix_out[c*PIX_W +: PIX_W]);
    endfunction

    function automatic longint cust(int i);
        if (i < 33) return i * i * 80;
        if (i == 33) return 32'h8000;
        return 32'h7FFFF;
    endfunction

    initial begin
        #(50000 * 5);
        n_fail++;
        $display("FAIL watchdog: got running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        @(posedge clk); #1 model_live = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state through the register interface
        rd_reg(2'd0, v); chk("R1 index", v, 0);
        rd_reg(2'd2, v); chk("R1 mode", v, 0);
        chk("R1 output", ch(0), 0);

        // R1/R4: walk the identity table with auto-increment
        wr_reg(2'd0, 32'h0000_8000);
        for (int i = 0; i < N_ENT; i++) begin
            rd_reg(2'd1, v); chk("R1/R4 entry", v, ident(i));
        end
        rd_reg(2'd0, v); chk("R5 index at end", v, 32'h8000 | 35);
        rd_reg(2'd1, v); chk("R5 read past end", v, 0);
        rd_reg(2'd0, v); chk("R5 index sticks", v, 32'h8000 | 35);

        // R3: ordering rule
        wr_reg(2'd0, 32'h0000_8005);
        rd_reg(2'd0, v); chk("R3 reload while set", v, 32'h8000 | 35);
        wr_reg(2'd0, 32'h0000_0007);
        rd_reg(2'd0, v); chk("R3 clear keeps index", v, 35);
        wr_reg(2'd0, 32'h0000_803F);
        rd_reg(2'd0, v); chk("R3 load clamps", v, 32'h8000 | 35);

        // R4: access without auto-increment
        wr_reg(2'd0, 32'h0);
        wr_reg(2'd0, 32'h0000_800A);
        wr_reg(2'd0, 32'h0);
        wr_reg(2'd1, 32'hFFF8_1234);
        rd_reg(2'd0, v); chk("R4 index held", v, 10);
        rd_reg(2'd1, v); chk("R4 stored low bits", v, 32'h1234);
        rd_reg(2'd1, v); chk("R4 read no advance", v, 32'h1234);

        // R10/R2: bypass, bit 30 ignored
        wr_reg(2'd2, 32'h4000_0000);
        rd_reg(2'd2, v); chk("R2 bit30 ignored", v, 0);
        put_pix(19'h12345, 19'h7FFFF, 19'h0);
        chk("R10 bypass", ch(0), 19'h12345);
        chk("R10 bypass max", ch(1), 19'h7FFFF);

        // restore identity entry 10 and enable
        wr_reg(2'd0, 32'h0000_800A);
        wr_reg(2'd1, 32'd20480);
        wr_reg(2'd2, 32'h8000_0000);
        rd_reg(2'd2, v); chk("R2 enable reads back", v, 32'h8000_0000);

        // R6-R9 on the identity curve, R12 channel independence
        put_pix(19'h08000, 19'h20000, 19'h50000);
        chk("R6 identity", ch(0), 19'h08000);
        chk("R7 identity", ch(1), 19'h20000);
        chk("R8 identity", ch(2), 19'h50000);
        put_pix(19'h7FFFF, 19'h10000, 19'h30000);
        chk("R9 clamp", ch(0), 19'h70000);
        chk("R7 at 1.0", ch(1), 19'h10000);
        chk("R8 at 3.0", ch(2), 19'h30000);

        // R11: output holds until the next edge
        pix_in[PIX_W-1:0] = 19'h00800;
        #1 chk("R11 latency hold", ch(0), 19'h70000);
        @(posedge clk); #1 chk("R11 after edge", ch(0), 19'h00800);

        // custom non-monotonic table, point at 1.0 above 1.0
        wr_reg(2'd0, 32'h0);
        wr_reg(2'd0, 32'h0000_8000);
        for (int i = 0; i < N_ENT; i++) wr_reg(2'd1, 32'(cust(i)));
        wr_reg(2'd1, 32'h0000_5555);
        wr_reg(2'd0, 32'h0);
        wr_reg(2'd0, 32'h0000_8022);
        rd_reg(2'd1, v); chk("R5 write past end ignored", v, 19'h7FFFF);

        put_pix(19'h0A400, 19'h20000, 19'h50000);
        chk("R6 custom", ch(0), 33640);
        chk("R7 falling slope", ch(1), 19'h0E000);
        chk("R8 custom", ch(2), 19'h43FFF);
        put_pix(19'h70000, 19'h10000, 19'h30000);
        chk("R9 custom", ch(0), 19'h7FFFF);
        chk("R7 custom at 1.0", ch(1), 81920);
        chk("R8 custom at 3.0", ch(2), 19'h08000);

        // random sweep against the model, then in bypass
        for (int k = 0; k < 400; k++)
            put_pix($urandom_range(0, 19'h7FFFF), $urandom_range(0, 19'h1FFFF),
                    $urandom_range(0, 19'h7FFFF));
        wr_reg(2'd2, 32'h0);
        for (int k = 0; k < 100; k++)
            put_pix($urandom_range(0, 19'h7FFFF), $urandom_range(0, 19'h7FFFF),
                    $urandom_range(0, 19'h7FFFF));

        @(posedge clk); #1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule